// File: doc/BRIEF.md
# Stack-Frame Push/Pop Micro-Op Sequencer

This block expands one 16-bit compressed stack-frame instruction into an ordered burst of micro-operations for a simple in-order core. Four operations are decoded: push, pop, pop-and-return, and pop-and-return with a zeroed a0. A 4-bit register-list code picks how many callee-saved registers take part. A 2-bit field adds extra stack space in 16-byte steps. The register width XLEN is a parameter, either 32 or 64. It sets the access size and the frame rounding.

An instruction and the current stack pointer arrive over a valid/ready input. Once accepted, the block emits one memory access per listed register, then a stack-pointer update. A pop that returns then adds an optional a0 clear and a return jump through ra. Micro-ops leave over a valid/ready output that carries a kind, a register index, an address or value, and an access size. Encodings that are not recognised, or that arrive while the enables forbid them, are consumed and flagged as illegal. They produce no micro-ops.

Top module: `stack_frame_seq`

## Requirements
- R1: An instruction is legal when instr[15:13]=101, instr[1:0]=10, compressed_en_i is high, cdouble_en_i is low and instr[12:8] is 11000 (push), 11010 (pop), 11100 (pop-return-zero) or 11110 (pop-return). Any other accepted instruction raises illegal_o for exactly the one cycle after acceptance and emits no micro-op.
- R2: The list code is instr[7:4]. Codes 0 to 3 are reserved and are treated as illegal, as in R1.
- R3: The register count n is code−3 for codes 4 to 14 and 13 for code 15. List position 0 is x1, position 1 is x8, position 2 is x9, and position k≥3 is x(15+k). Accesses go out in increasing position order.
- R4: With B=XLEN/8, the access at position k uses address base−(k+1)·B modulo 2^XLEN. The base is the old sp for push and the old sp plus the adjustment for the pop forms.
- R5: Push accesses are kind 0 (store) and pop-form accesses are kind 1 (load). uop_size_o is log2(B) (2 or 3) on accesses and 0 on every other kind.
- R6: The adjustment is the smallest multiple of 16 that is at least n·B, plus 16 times instr[3:2]. After the accesses, a kind 2 micro-op with register 2 carries the new sp: old−adjustment for push, old+adjustment for the pops.
- R7: Push and pop end with the sp update. Pop-return-zero emits kind 3 (register 10, value 0) before the sp update and kind 4 (register 1) after it. Pop-return emits the sp update and then kind 4 (register 1).
- R8: The micro-op output holds all its fields stable while uop_valid_o is high and uop_ready_i is low. It advances by one micro-op per handshake.
- R9: After reset the block is idle: instr_ready_o high, busy_o, uop_valid_o and illegal_o low. While a sequence runs, busy_o is high and instr_ready_o is low. In the cycle after the last handshake the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| compressed_en_i | input | 1 | Compressed instruction support enabled |
| cdouble_en_i | input | 1 | Compressed double-float support enabled (blocks decoding) |
| instr_valid_i | input | 1 | Instruction offered |
| instr_ready_o | output | 1 | Instruction can be taken |
| instr_i | input | 16 | Compressed instruction |
| sp_i | input | XLEN | Current stack pointer |
| uop_valid_o | output | 1 | Micro-op offered |
| uop_ready_i | input | 1 | Micro-op taken |
| uop_kind_o | output | 3 | 0 store, 1 load, 2 sp write, 3 a0 clear, 4 return |
| uop_reg_o | output | 5 | Register index |
| uop_addr_o | output | XLEN | Access address or new sp value |
| uop_size_o | output | 2 | log2 of access bytes |
| busy_o | output | 1 | Sequence in progress |
| illegal_o | output | 1 | One-cycle flag for a rejected instruction |

## Verification
Both widths are swept over every operation, every legal list code and every extra-space value. Each micro-op is compared field by field against a frame computed arithmetically. The rounding sweep separates the width-dependent frame sizes, and the list codes near 14 and 15 show the two-register step at the end of the list. A pseudo-random ready pattern stalls the output at arbitrary points, which tells a held micro-op apart from one that slips or repeats. Reserved list codes, mismatched opcode bits and both enable conditions each have to produce the illegal pulse with no micro-op. A low starting sp wraps the push addresses.

// File: rtl/stack_frame_pkg.sv
package stack_frame_pkg;
  localparam int CNT_W = 4;
  localparam int REG_W = 5;
  localparam int ADJ_W = 8;

  localparam logic [REG_W-1:0] REG_RA = 5'd1;
  localparam logic [REG_W-1:0] REG_SP = 5'd2;
  localparam logic [REG_W-1:0] REG_A0 = 5'd10;

  typedef enum logic [2:0] {
    UOP_STORE = 3'd0,
    UOP_LOAD  = 3'd1,
    UOP_SPWR  = 3'd2,
    UOP_ZERO  = 3'd3,
    UOP_RET   = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    FOP_PUSH,
    FOP_POP,
    FOP_POPRETZ,
    FOP_POPRET
  } frame_op_e;

  typedef enum logic [1:0] {
    PH_ACC,
    PH_ZERO,
    PH_SPWR,
    PH_RET
  } phase_e;
endpackage

// File: rtl/stack_frame_dec.sv
module stack_frame_dec
  import stack_frame_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0]      instr_i,
  input  logic             compressed_en_i,
  input  logic             cdouble_en_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic             legal_o,
  output frame_op_e        op_o,
  output logic [CNT_W-1:0] nregs_o,
  output logic [XLEN-1:0]  base_o,
  output logic [XLEN-1:0]  newsp_o
);
  localparam int BYTES = XLEN / 8;

  logic             op_ok;
  logic [3:0]       rlist;
  logic [ADJ_W-1:0] raw, rounded, adj;
  logic [XLEN-1:0]  adj_x;

  always_comb begin
    op_ok = 1'b1;
    case (instr_i[12:8])
      5'b11000: op_o = FOP_PUSH;
      5'b11010: op_o = FOP_POP;
      5'b11100: op_o = FOP_POPRETZ;
      5'b11110: op_o = FOP_POPRET;
      default: begin
        op_o  = FOP_PUSH;
        op_ok = 1'b0;
      end
    endcase
  end

  assign rlist   = instr_i[7:4];
  assign nregs_o = (rlist == 4'hf) ? CNT_W'(13) : rlist - 4'd3;

  // frame rounded up to 16 bytes, then extra space
  assign raw     = ADJ_W'(nregs_o) * ADJ_W'(BYTES);
  assign rounded = (raw + ADJ_W'(15)) & ~ADJ_W'(15);
  assign adj     = rounded + {2'b00, instr_i[3:2], 4'b0000};
  assign adj_x   = {{(XLEN-ADJ_W){1'b0}}, adj};

  assign legal_o = compressed_en_i && !cdouble_en_i &&
                   (instr_i[15:13] == 3'b101) && (instr_i[1:0] == 2'b10) &&
                   op_ok && (rlist >= 4'd4);

  assign base_o  = (op_o == FOP_PUSH) ? sp_i : sp_i + adj_x;
  assign newsp_o = (op_o == FOP_PUSH) ? sp_i - adj_x : sp_i + adj_x;
endmodule

// File: rtl/stack_frame_regmap.sv
module stack_frame_regmap
  import stack_frame_pkg::*;
(
  input  logic [CNT_W-1:0] pos_i,
  output logic [REG_W-1:0] reg_o
);
  always_comb begin
    case (pos_i)
      4'd0:    reg_o = REG_RA;
      4'd1:    reg_o = 5'd8;
      4'd2:    reg_o = 5'd9;
      default: reg_o = REG_W'(pos_i) + 5'd15;
    endcase
  end
endmodule

// File: rtl/stack_frame_fsm.sv
module stack_frame_fsm
  import stack_frame_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             legal_i,
  input  frame_op_e        op_i,
  input  logic [CNT_W-1:0] nregs_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  newsp_i,
  input  logic             uop_ready_i,
  output logic             active_o,
  output logic             illegal_o,
  output logic [2:0]       kind_o,
  output logic [REG_W-1:0] reg_o,
  output logic [XLEN-1:0]  addr_o,
  output logic [1:0]       size_o
);
  localparam int SIZE_CODE = $clog2(XLEN / 8);

  logic             active_q, illegal_q;
  phase_e           phase_q;
  frame_op_e        op_q;
  logic [CNT_W-1:0] pos_q, nregs_q;
  logic [XLEN-1:0]  base_q, newsp_q, off;
  logic [REG_W-1:0] list_reg;
  uop_kind_e        kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      illegal_q <= 1'b0;
      phase_q   <= PH_ACC;
      op_q      <= FOP_PUSH;
      pos_q     <= '0;
      nregs_q   <= '0;
      base_q    <= '0;
      newsp_q   <= '0;
    end else begin
      illegal_q <= accept_i && !legal_i;
      if (accept_i && legal_i) begin
        active_q <= 1'b1;
        phase_q  <= PH_ACC;
        pos_q    <= '0;
        op_q     <= op_i;
        nregs_q  <= nregs_i;
        base_q   <= base_i;
        newsp_q  <= newsp_i;
      end else if (active_q && uop_ready_i) begin
        case (phase_q)
          PH_ACC:
            if (pos_q == nregs_q - 4'd1)
              phase_q <= (op_q == FOP_POPRETZ) ? PH_ZERO : PH_SPWR;
            else
              pos_q <= pos_q + 4'd1;
          PH_ZERO: phase_q <= PH_SPWR;
          PH_SPWR:
            if (op_q == FOP_POPRETZ || op_q == FOP_POPRET) phase_q <= PH_RET;
            else active_q <= 1'b0;
          default: active_q <= 1'b0;
        endcase
      end
    end
  end

  stack_frame_regmap i_regmap (
    .pos_i (pos_q),
    .reg_o (list_reg)
  );

  assign off = {{(XLEN-CNT_W-1){1'b0}}, ({1'b0, pos_q} + 5'd1)} << SIZE_CODE;

  always_comb begin
    kind   = UOP_SPWR;
    reg_o  = '0;
    addr_o = '0;
    size_o = 2'd0;
    case (phase_q)
      PH_ACC: begin
        kind   = (op_q == FOP_PUSH) ? UOP_STORE : UOP_LOAD;
        reg_o  = list_reg;
        addr_o = base_q - off;
        size_o = 2'(SIZE_CODE);
      end
      PH_ZERO: begin
        kind  = UOP_ZERO;
        reg_o = REG_A0;
      end
      PH_SPWR: begin
        kind   = UOP_SPWR;
        reg_o  = REG_SP;
        addr_o = newsp_q;
      end
      default: begin
        kind  = UOP_RET;
        reg_o = REG_RA;
      end
    endcase
  end

  assign kind_o    = kind;
  assign active_o  = active_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stack_frame_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            compressed_en_i,
  input  logic            cdouble_en_i,
  input  logic            instr_valid_i,
  output logic            instr_ready_o,
  input  logic [15:0]     instr_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            uop_valid_o,
  input  logic            uop_ready_i,
  output logic [2:0]      uop_kind_o,
  output logic [4:0]      uop_reg_o,
  output logic [XLEN-1:0] uop_addr_o,
  output logic [1:0]      uop_size_o,
  output logic            busy_o,
  output logic            illegal_o
);
  logic             legal, active, accept;
  frame_op_e        op;
  logic [CNT_W-1:0] nregs;
  logic [XLEN-1:0]  base, newsp;

  assign accept = instr_valid_i && !active;

  stack_frame_dec #(.XLEN(XLEN)) i_dec (
    .instr_i         (instr_i),
    .compressed_en_i (compressed_en_i),
    .cdouble_en_i    (cdouble_en_i),
    .sp_i            (sp_i),
    .legal_o         (legal),
    .op_o            (op),
    .nregs_o         (nregs),
    .base_o          (base),
    .newsp_o         (newsp)
  );

  stack_frame_fsm #(.XLEN(XLEN)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .legal_i     (legal),
    .op_i        (op),
    .nregs_i     (nregs),
    .base_i      (base),
    .newsp_i     (newsp),
    .uop_ready_i (uop_ready_i),
    .active_o    (active),
    .illegal_o   (illegal_o),
    .kind_o      (uop_kind_o),
    .reg_o       (uop_reg_o),
    .addr_o      (uop_addr_o),
    .size_o      (uop_size_o)
  );

  assign instr_ready_o = !active;
  assign uop_valid_o   = active;
  assign busy_o        = active;
endmodule

// File: rtl/stack_frame_seq_chk.sv
module stack_frame_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_valid_i,
  input logic            instr_ready_o,
  input logic            uop_valid_o,
  input logic            uop_ready_i,
  input logic [2:0]      uop_kind_o,
  input logic [4:0]      uop_reg_o,
  input logic [XLEN-1:0] uop_addr_o,
  input logic [1:0]      uop_size_o,
  input logic            busy_o,
  input logic            illegal_o
);
  localparam int SIZE_CODE = $clog2(XLEN / 8);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o) &&
      $stable(uop_reg_o) && $stable(uop_addr_o) && $stable(uop_size_o));

  p_accept_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_ready_o |=> busy_o != illegal_o);

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !instr_ready_o);

  p_illegal_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !uop_valid_o);

  p_first_is_ra_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uop_valid_o) |-> uop_reg_o == 5'd1 && uop_kind_o <= 3'd1);

  p_access_size_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_kind_o <= 3'd1 |-> uop_size_o == 2'(SIZE_CODE));

  p_return_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_kind_o == 3'd4 |=> !uop_valid_o);
endmodule

bind stack_frame_seq stack_frame_seq_chk #(.XLEN(XLEN)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_ready_o (instr_ready_o),
  .uop_valid_o   (uop_valid_o),
  .uop_ready_i   (uop_ready_i),
  .uop_kind_o    (uop_kind_o),
  .uop_reg_o     (uop_reg_o),
  .uop_addr_o    (uop_addr_o),
  .uop_size_o    (uop_size_o),
  .busy_o        (busy_o),
  .illegal_o     (illegal_o)
);

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_c = 1'b1, en_cd = 1'b0;
  logic        ivalid = 1'b0, sel64 = 1'b0, uready = 1'b0;
  logic [15:0] instr = '0;
  logic [63:0] sp = '0;
  logic [15:0] lfsr = 16'hace1;

  always #4 clk = ~clk;

  logic        ir32, uv32, b32, il32, ir64, uv64, b64, il64;
  logic [2:0]  k32, k64;
  logic [4:0]  r32, r64;
  logic [1:0]  s32, s64;
  logic [31:0] a32;
  logic [63:0] a64;

  stack_frame_seq #(.XLEN(32)) i_stack_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .compressed_en_i(en_c), .cdouble_en_i(en_cd),
    .instr_valid_i(ivalid && !sel64), .instr_ready_o(ir32), .instr_i(instr),
    .sp_i(sp[31:0]), .uop_valid_o(uv32), .uop_ready_i(uready), .uop_kind_o(k32),
    .uop_reg_o(r32), .uop_addr_o(a32), .uop_size_o(s32), .busy_o(b32), .illegal_o(il32));

  stack_frame_seq #(.XLEN(64)) i_stack_frame_seq_64 (
    .clk_i(clk), .rst_ni(rst_n), .compressed_en_i(en_c), .cdouble_en_i(en_cd),
    .instr_valid_i(ivalid && sel64), .instr_ready_o(ir64), .instr_i(instr),
    .sp_i(sp), .uop_valid_o(uv64), .uop_ready_i(uready), .uop_kind_o(k64),
    .uop_reg_o(r64), .uop_addr_o(a64), .uop_size_o(s64), .busy_o(b64), .illegal_o(il64));

  logic        c_ir, c_uv, c_busy, c_ill;
  logic [2:0]  c_kind;
  logic [4:0]  c_reg;
  logic [1:0]  c_size;
  logic [63:0] c_addr;

  always_comb begin
    c_ir   = sel64 ? ir64 : ir32;
    c_uv   = sel64 ? uv64 : uv32;
    c_busy = sel64 ? b64 : b32;
    c_ill  = sel64 ? il64 : il32;
    c_kind = sel64 ? k64 : k32;
    c_reg  = sel64 ? r64 : r32;
    c_size = sel64 ? s64 : s32;
    c_addr = sel64 ? a64 : {32'h0, a32};
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s xlen=%0d instr=%h: actual %h expected %h", req, sel64 ? 64 : 32, instr, act, exp);
    end
  endtask

  function automatic int opfield(input int op);
    case (op)
      0: return 5'b11000;
      1: return 5'b11010;
      2: return 5'b11100;
      default: return 5'b11110;
    endcase
  endfunction

  function automatic int nregs(input int rl);
    return (rl == 15) ? 13 : rl - 3;
  endfunction

  task automatic exp_uop(input int xl, input int op, input int rl, input int spi,
                         input logic [63:0] spv, input int j, output int ek, output int er,
                         output logic [63:0] ea, output int es);
    int n, b, adj, t;
    logic [63:0] base, nsp;
    n = nregs(rl);
    b = xl / 8;
    adj = ((n * b + 15) / 16) * 16 + 16 * spi;
    base = (op == 0) ? spv : spv + 64'(adj);
    nsp  = (op == 0) ? spv - 64'(adj) : spv + 64'(adj);
    if (j < n) begin
      ek = (op == 0) ? 0 : 1;
      er = (j == 0) ? 1 : (j == 1) ? 8 : (j == 2) ? 9 : 15 + j;
      ea = base - 64'((j + 1) * b);
      es = (xl == 32) ? 2 : 3;
    end else begin
      t = j - n;
      es = 0;
      ea = '0;
      if (op == 2 && t == 0) begin
        ek = 3; er = 10;
      end else begin
        if (op == 2) t = t - 1;
        if (t == 0) begin
          ek = 2; er = 2; ea = nsp;
        end else begin
          ek = 4; er = 1;
        end
      end
    end
    if (xl == 32) ea = ea & 64'hffff_ffff;
  endtask

  task automatic run_legal(input bit s, input int op, input int rl, input int spi, input logic [63:0] spv);
    int n, total, j, guard, ek, er, es, xl;
    logic [63:0] ea, paddr;
    logic [2:0] pk;
    logic [4:0] pr;
    logic [1:0] ps;
    bit hold;
    xl = s ? 64 : 32;
    n = nregs(rl);
    total = n + 1 + ((op == 2) ? 1 : 0) + ((op >= 2) ? 1 : 0);
    @(negedge clk);
    sel64 = s;
    instr = {3'b101, 5'(opfield(op)), 4'(rl), 2'(spi), 2'b10};
    sp = spv;
    chk(c_ir == 1'b1, "R9 ready when idle", 64'(c_ir), 64'd1);
    ivalid = 1'b1;
    @(negedge clk);
    ivalid = 1'b0;
    j = 0; guard = 0; hold = 1'b0;
    pk = '0; pr = '0; ps = '0; paddr = '0;
    while (j < total && guard < 100) begin
      guard++;
      chk(c_busy && !c_ir, "R9 busy blocks input", {62'h0, c_busy, c_ir}, 64'h2);
      if (!c_uv) begin
        chk(1'b0, "R8 valid during sequence", 64'(c_uv), 64'd1);
        break;
      end
      if (hold)
        chk(c_kind == pk && c_reg == pr && c_addr == paddr && c_size == ps,
            "R8 held under stall", c_addr, paddr);
      exp_uop(xl, op, rl, spi, spv, j, ek, er, ea, es);
      chk(c_kind == 3'(ek), (j < n) ? "R5 kind" : "R7 kind", 64'(c_kind), 64'(ek));
      chk(c_reg == 5'(er), "R3 register", 64'(c_reg), 64'(er));
      chk(c_addr == ea, (j < n) ? "R4 address" : "R6 sp value", c_addr, ea);
      chk(c_size == 2'(es), "R5 size", 64'(c_size), 64'(es));
      uready = lfsr[0] | lfsr[2];
      hold = !uready;
      pk = c_kind; pr = c_reg; ps = c_size; paddr = c_addr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      if (uready) j++;
    end
    uready = 1'b0;
    chk(!c_uv && c_ir && !c_busy, "R9 idle after last", {61'h0, c_uv, c_ir, c_busy}, 64'h2);
  endtask

  task automatic run_bad(input bit s, input logic [15:0] ins, input logic ec, input logic ecd, input string req);
    @(negedge clk);
    sel64 = s;
    instr = ins;
    en_c = ec;
    en_cd = ecd;
    ivalid = 1'b1;
    @(negedge clk);
    ivalid = 1'b0;
    chk(c_ill == 1'b1, req, 64'(c_ill), 64'd1);
    chk(!c_uv && c_ir, req, {62'h0, c_uv, c_ir}, 64'h1);
    @(negedge clk);
    chk(c_ill == 1'b0 && !c_uv, req, {62'h0, c_ill, c_uv}, 64'h0);
    en_c = 1'b1;
    en_cd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      sel64 = s[0];
      chk(c_ir && !c_uv && !c_busy && !c_ill, "R9 reset state",
          {60'h0, c_ir, c_uv, c_busy, c_ill}, 64'h8);
    end
    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 4; op++)
        for (int rl = 4; rl < 16; rl++)
          for (int spi = 0; spi < 4; spi++)
            run_legal(s[0], op, rl, spi,
                      (rl == 15 && op == 0) ? 64'h40 : 64'h0000_0012_8000_1000 + 64'(rl * 256 + spi * 64));
    for (int s = 0; s < 2; s++) begin
      for (int op = 0; op < 4; op++)
        for (int rl = 0; rl < 4; rl++)
          run_bad(s[0], {3'b101, 5'(opfield(op)), 4'(rl), 2'b01, 2'b10}, 1'b1, 1'b0, "R2 reserved list");
      run_bad(s[0], {3'b100, 5'b11000, 4'h6, 2'b00, 2'b10}, 1'b1, 1'b0, "R1 top bits");
      run_bad(s[0], {3'b101, 5'b11000, 4'h6, 2'b00, 2'b01}, 1'b1, 1'b0, "R1 low bits");
      run_bad(s[0], {3'b101, 5'b11001, 4'h6, 2'b00, 2'b10}, 1'b1, 1'b0, "R1 op field");
      run_bad(s[0], {3'b101, 5'b10000, 4'h6, 2'b00, 2'b10}, 1'b1, 1'b0, "R1 op field");
      run_bad(s[0], {3'b101, 5'b11010, 4'h6, 2'b00, 2'b10}, 1'b0, 1'b0, "R1 compressed disabled");
      run_bad(s[0], {3'b101, 5'b11010, 4'h6, 2'b00, 2'b10}, 1'b1, 1'b1, "R1 double-compressed enabled");
      run_legal(s[0], 3, 6, 1, 64'h2000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule